// File: doc/BRIEF.md
# Dual-Direction Priority Encoder

This block takes a vector of request bits and, in a single evaluation, reports two positions: the highest-numbered request bit that is set and the lowest-numbered request bit that is set. Each position is a binary index and has its own valid flag. A typical use is a scheduler or allocator that needs both ends of an occupancy mask at once. Examples are the oldest and newest entries of a queue, or the first free and last used slot.

Both results come from one balanced OR tree. Every internal node of the tree holds the OR of an aligned power-of-two group of request bits. Those group ORs steer two index-merge trees, one that prefers the upper half of each pair and one that prefers the lower half. This keeps the depth logarithmic in the width, and both directions reuse the same OR terms. An optional output register stage, enabled by a parameter, lets the block sit on a timing-critical path. Its synchronous active-low reset clears all outputs.

Top module: `bidir_prio_enc`

## Requirements
- R1: `hi_vld` and `lo_vld` are both 1 exactly when at least one bit of `req` is 1, and both 0 when `req` is all zeros.
- R2: When valid, `hi_idx` equals the position of the most significant 1 in `req`, with bit 0 as the least significant position.
- R3: When valid, `lo_idx` equals the position of the least significant 1 in `req`.
- R4: When no request bit is set, `hi_idx` and `lo_idx` are both 0.
- R5: When exactly one bit of `req` is set, `hi_idx` and `lo_idx` both equal that bit's position.
- R6: When every bit of `req` is set, `hi_idx` equals WIDTH-1 and `lo_idx` equals 0.
- R7: With REG_OUT=1, the outputs reflect the `req` value sampled at the previous rising clock edge and hold until the next edge. With REG_OUT=0, the outputs follow `req` in the same cycle.
- R8: With REG_OUT=1, a rising edge with `rst_n` low drives all four outputs to 0, whatever `req` is.
- R9: Whenever the outputs are valid, `hi_idx` is greater than or equal to `lo_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | WIDTH | Request vector, bit 0 least significant |
| hi_idx | output | IDXW | Index of the most significant set request bit |
| hi_vld | output | 1 | Any request bit set (upper result) |
| lo_idx | output | IDXW | Index of the least significant set request bit |
| lo_vld | output | 1 | Any request bit set (lower result) |

## Verification
The bench builds two copies of the block.

- The first uses WIDTH=32 with the output register enabled. It covers reset clearing, one-cycle latency, every one-hot pattern, the all-zero and all-one vectors, and pseudo-random masks.
- The second uses WIDTH=8 with REG_OUT=0. The narrow width makes all 256 request patterns reachable, so the tree's merge selects are checked exhaustively in the same cycle as the input. The same instance also confirms that the purely combinational variant elaborates.

// File: rtl/bidir_prio_pkg.sv
// Shared helpers for the dual-direction priority encoder.
// Assumes widths are powers of two; tree nodes are stored flat, level by level.
package bidir_prio_pkg;

    // True when n is a power of two and at least 2.
    function automatic bit is_pow2(input int n);
        return (n >= 2) && ((n & (n - 1)) == 0);
    endfunction

    // Flat offset of the first node of tree level lvl for a tree of w leaves.
    function automatic int lvl_off(input int w, input int lvl);
        return 2 * w - 2 * (w >> lvl);
    endfunction

endpackage

// File: rtl/prio_or_tree.sv
// Balanced OR tree over the request vector.
// Level 0 holds the raw request bits; each higher node ORs an aligned pair below it.
// Output is flat: level l starts at lvl_off(WIDTH, l); the root is the last bit.
// Assumes WIDTH is a power of two and LVLS = log2(WIDTH).
module prio_or_tree
    import bidir_prio_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int LVLS  = $clog2(WIDTH),
    localparam int NODES = 2 * WIDTH - 1
) (
    input  logic [WIDTH-1:0] req,
    output logic [NODES-1:0] grp
);

    // Leaves: copy the request bits.
    assign grp[WIDTH-1:0] = req;

    // Internal nodes: OR of the two children one level down.
    for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
        localparam int CNT  = WIDTH >> l;
        localparam int OFF  = lvl_off(WIDTH, l);
        localparam int COFF = lvl_off(WIDTH, l - 1);
        for (genvar n = 0; n < CNT; n++) begin : g_node
            assign grp[OFF + n] = grp[COFF + 2 * n] | grp[COFF + 2 * n + 1];
        end
    end

endmodule

// File: rtl/prio_idx_merge.sv
// Two index-merge trees steered by the shared group ORs.
// At each node the upper-priority path takes the upper child whenever it holds a request.
// The lower-priority path takes the upper child only when the lower child is empty and the upper one is not.
// With no request anywhere, both paths settle on index 0.
// Assumes grp comes from prio_or_tree with the same WIDTH; the root bit is not needed here.
module prio_idx_merge
    import bidir_prio_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int LVLS  = $clog2(WIDTH),
    parameter int IDXW  = $clog2(WIDTH),
    localparam int NODES = 2 * WIDTH - 1
) (
    input  logic [NODES-2:0] grp,
    output logic [IDXW-1:0]  hi_root,
    output logic [IDXW-1:0]  lo_root
);

    logic [IDXW-1:0] hi_node [NODES];
    logic [IDXW-1:0] lo_node [NODES];

    // Leaves carry no index bits yet.
    for (genvar n = 0; n < WIDTH; n++) begin : g_leaf
        assign hi_node[n] = '0;
        assign lo_node[n] = '0;
    end

    // Each level adds one index bit, chosen by the children's group ORs.
    for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
        localparam int CNT  = WIDTH >> l;
        localparam int OFF  = lvl_off(WIDTH, l);
        localparam int COFF = lvl_off(WIDTH, l - 1);
        localparam logic [IDXW-1:0] BIT = IDXW'(1) << (l - 1);
        for (genvar n = 0; n < CNT; n++) begin : g_node
            localparam int CL = COFF + 2 * n;
            localparam int CH = CL + 1;
            logic take_hi_up;
            logic take_lo_up;
            assign take_hi_up = grp[CH];
            assign take_lo_up = grp[CH] & ~grp[CL];
            assign hi_node[OFF + n] = take_hi_up ? (hi_node[CH] | BIT) : hi_node[CL];
            assign lo_node[OFF + n] = take_lo_up ? (lo_node[CH] | BIT) : lo_node[CL];
        end
    end

    assign hi_root = hi_node[NODES-1];
    assign lo_root = lo_node[NODES-1];

endmodule

// File: rtl/prio_out_stage.sv
// Optional output register for the encoder results.
// REG_OUT=1: registered on the rising edge, cleared by synchronous active-low reset.
// REG_OUT=0: pass-through; clk and rst_n are then not used.
module prio_out_stage #(
    parameter int  DW      = 12,
    parameter bit  REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);

    if (REG_OUT) begin : g_reg
        logic [DW-1:0] q_r;
        // Capture the combinational results, or clear them on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= d;
        end
        assign q = q_r;
    end else begin : g_comb
        assign q = d;
    end

endmodule

// File: rtl/bidir_prio_enc.sv
// Dual-direction priority encoder: reports the highest and lowest set request bits.
// One OR tree feeds two merge trees; an optional register stage follows.
// Assumes WIDTH is a power of two, at least 2. Synchronous active-low reset.
module bidir_prio_enc
    import bidir_prio_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int IDXW   = $clog2(WIDTH),
    localparam int LVLS   = $clog2(WIDTH),
    localparam int NODES  = 2 * WIDTH - 1,
    localparam int DW     = 2 * IDXW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] req,
    output logic [IDXW-1:0]  hi_idx,
    output logic             hi_vld,
    output logic [IDXW-1:0]  lo_idx,
    output logic             lo_vld
);

    logic [NODES-1:0] grp;
    logic [IDXW-1:0]  c_hi;
    logic [IDXW-1:0]  c_lo;
    logic             c_vld;
    logic [DW-1:0]    q;

    initial begin
        width_pow2_chk: assert (is_pow2(WIDTH));
    end

    prio_or_tree #(.WIDTH(WIDTH), .LVLS(LVLS)) u_tree (
        .req (req),
        .grp (grp)
    );

    prio_idx_merge #(.WIDTH(WIDTH), .LVLS(LVLS), .IDXW(IDXW)) u_merge (
        .grp     (grp[NODES-2:0]),
        .hi_root (c_hi),
        .lo_root (c_lo)
    );

    assign c_vld = grp[NODES-1];

    prio_out_stage #(.DW(DW), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({c_vld, c_hi, c_vld, c_lo}),
        .q     (q)
    );

    assign {hi_vld, hi_idx, lo_vld, lo_idx} = q;

    // Marks cycles after the first post-reset edge, for checks that look back.
    logic primed;
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // R1
    any_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_vld == (req != '0));
    // R2
    hi_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_vld |-> req[c_hi]);
    // R2
    hi_none_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_vld |-> ((req >> c_hi) >> 1) == '0);
    // R3
    lo_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_vld |-> req[c_lo]);
    // R3
    lo_none_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_vld |-> (req & ((WIDTH'(1) << c_lo) - WIDTH'(1))) == '0);
    // R9
    idx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_vld |-> c_hi >= c_lo);
    // R4
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !hi_vld |-> hi_idx == '0 && lo_idx == '0 && !lo_vld);

    if (REG_OUT) begin : g_lat_chk
        // R7
        reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> hi_vld == ($past(req) != '0));
    end

endmodule

// File: tb/bidir_prio_enc_test.sv
// Directed bench: one task per scenario, each checks its own results.
module bidir_prio_enc_test;

    localparam int W  = 32;
    localparam int IW = 5;
    localparam int WS = 8;
    localparam int IS = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  req = '0;
    logic [IW-1:0] hi_idx, lo_idx;
    logic          hi_vld, lo_vld;
    logic [WS-1:0] req_s = '0;
    logic [IS-1:0] hi_idx_s, lo_idx_s;
    logic          hi_vld_s, lo_vld_s;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    bidir_prio_enc #(.WIDTH(W), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .req(req),
        .hi_idx(hi_idx), .hi_vld(hi_vld), .lo_idx(lo_idx), .lo_vld(lo_vld)
    );

    bidir_prio_enc #(.WIDTH(WS), .REG_OUT(1'b0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .req(req_s),
        .hi_idx(hi_idx_s), .hi_vld(hi_vld_s), .lo_idx(lo_idx_s), .lo_vld(lo_vld_s)
    );

    // Behavioural reference: scan all bits, keeping the last and first set positions.
    function automatic void model(input logic [W-1:0] v, input int w,
                                  output int hi, output int lo, output bit vld);
        hi = 0; lo = 0; vld = 1'b0;
        for (int i = 0; i < w; i++) begin
            if (v[i]) begin
                hi = i;
                if (!vld) lo = i;
                vld = 1'b1;
            end
        end
    endfunction

    task automatic check_big(input logic [W-1:0] v, input string tag);
        int eh, el; bit ev;
        model(v, W, eh, el, ev);
        n_chk++;
        if (hi_vld !== ev || lo_vld !== ev || hi_idx !== IW'(eh) || lo_idx !== IW'(el)) begin
            n_bad++;
            $display("FAIL %s req=%h got vld=%b/%b hi=%0d lo=%0d exp vld=%b hi=%0d lo=%0d",
                     tag, v, hi_vld, lo_vld, hi_idx, lo_idx, ev, eh, el);
        end
    endtask

    task automatic check_small(input logic [WS-1:0] v, input string tag);
        int eh, el; bit ev;
        model(W'(v), WS, eh, el, ev);
        n_chk++;
        if (hi_vld_s !== ev || lo_vld_s !== ev || hi_idx_s !== IS'(eh) || lo_idx_s !== IS'(el)) begin
            n_bad++;
            $display("FAIL %s req=%h got vld=%b/%b hi=%0d lo=%0d exp vld=%b hi=%0d lo=%0d",
                     tag, v, hi_vld_s, lo_vld_s, hi_idx_s, lo_idx_s, ev, eh, el);
        end
    endtask

    // Drive at a falling edge, let one rising edge register it, sample at the next falling edge.
    task automatic apply(input logic [W-1:0] v, input string tag);
        @(negedge clk) req = v;
        @(negedge clk) check_big(v, tag);
    endtask

    // R8: outputs are cleared while reset is held, even with every request set.
    task automatic t_reset();
        rst_n = 1'b0;
        @(negedge clk) req = '1;
        @(negedge clk);
        n_chk++;
        if ({hi_vld, lo_vld, hi_idx, lo_idx} !== '0) begin
            n_bad++;
            $display("FAIL R8 got vld=%b/%b hi=%0d lo=%0d exp all 0", hi_vld, lo_vld, hi_idx, lo_idx);
        end
        @(negedge clk) req = '0;
        rst_n = 1'b1;
    endtask

    // R1 and R4: empty request vector.
    task automatic t_zero();
        apply('0, "R1_R4_empty");
    endtask

    // R5, R2 and R3: every one-hot vector.
    task automatic t_onehot();
        for (int i = 0; i < W; i++) apply(W'(1) << i, "R5_R2_R3_onehot");
    endtask

    // R6: every request set.
    task automatic t_allones();
        apply('1, "R6_allones");
    endtask

    // R2, R3 and R9: pseudo-random masks, including sparse ones.
    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] v;
            v = $urandom();
            if (i % 3 == 0) v = v & $urandom() & $urandom();
            apply(v, "R2_R3_R9_random");
        end
        apply(32'h8000_0001, "R2_R3_R9_ends");
        apply(32'h0001_8000, "R2_R3_R9_middle");
    endtask

    // R7: registered output holds the old result until the next rising edge.
    task automatic t_latency();
        apply(32'h0000_0F00, "R7_first");
        @(negedge clk) req = 32'h0030_0002;
        #1 check_big(32'h0000_0F00, "R7_hold");
        @(negedge clk) check_big(32'h0030_0002, "R7_update");
    endtask

    // R7, R2 and R3: combinational 8-bit copy, all patterns, checked in the same cycle.
    task automatic t_comb_exhaustive();
        for (int i = 0; i < 256; i++) begin
            req_s = WS'(i);
            #2 check_small(WS'(i), "R7_R2_R3_comb");
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_zero();
        t_onehot();
        t_allones();
        t_random();
        t_latency();
        t_comb_exhaustive();
        t_reset();
        finish_run();
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule